// File: doc/BRIEF.md
# Frame Buffer Fetch Bus Master

This block is the memory-reading half of a display pipeline. It reads one frame of stored pixels from system memory over a 32-bit WISHBONE-style master port. It turns each stored pixel into a 24-bit RGB value and pushes that value into a line FIFO that a separate video timing stage drains. A frame is the visible rectangle, the visible pixels per line times the visible lines per frame. It is read as ascending word addresses that start at the active page base.

Two page base addresses let software draw into one page while the other is shown. When page switching is enabled, the active page flips at every frame end, and a one-cycle pulse reports each flip. Stored pixels can be 8, 16, 24 or 32 bits wide. In 8-bit mode a pixel is either greyscale or an index into a 256-entry colour table in memory. That table has two banks, and the active bank can also flip at frame end. Reads are grouped into bursts of a programmable length. A burst is issued only when the FIFO can absorb every pixel that burst will produce. A bus error stops the master and raises an interrupt that stays set until reset.

Top module: `fbf_fetch_master`

## Requirements
- R1: Every bus request is a read (`m_we`=0) with all four byte selects set (`m_sel`=4'hF). `m_adr` carries byte-address bits 31:2.
- R2: `burst_sel` values 0,1,2,3 give 1,2,4,8 words per burst. The last burst of a frame is cut to the words left in the frame. `m_cab` is high during a video burst exactly when that burst has more than one word.
- R3: A video burst starts only when `fifo_free` is at least the burst's words times the pixels per word. `pix_wr` is never high while `fifo_full` is high.
- R4: A frame is `width_px`*`height_ln` pixels. Its video words are read at consecutive word addresses from the active page base, which is `base_a` when `page_sel`=0 and `base_b` when `page_sel`=1.
- R5: `pix_data` holds red in bits 23:16, green in 15:8 and blue in 7:0. The `depth_sel` field selects the stored format, and lower pixels in a word come first. Value 1 is 16-bit 5-6-5 (red 15:11, green 10:5, blue 4:0, two pixels per word), and each channel is widened by repeating its top bits. Value 2 is one pixel per word in bits 23:0. Value 3 is one pixel per word in bits 31:8.
- R6: `depth_sel`=0 packs four 8-bit pixels per word. With `pseudo_en`=0 the byte is copied to all three channels. With `pseudo_en`=1 the master makes a single read at word address {`clut_base`, `clut_sel`, byte} and outputs bits 23:0 of the returned word.
- R7: With `page_swap_en`=1, `page_sel` toggles after the last pixel of each frame, and `swap_pulse` is high for the single cycle in which the new value first shows.
- R8: With `clut_swap_en`=1, `clut_sel` toggles after the last pixel of each frame. It does not toggle when the enable is 0.
- R9: An error response ends the request at once. `fatal_irq` rises and stays high until reset. No request is made until `video_en` has been low.
- R10: While `video_en` is low there are no bus requests and no pixel writes. Raising it starts a new frame at the active page base.
- R11: After reset, `page_sel`, `clut_sel`, `swap_pulse`, `fatal_irq`, `m_cyc` and `pix_wr` are 0.
- R12: A request keeps `m_stb` and `m_adr` unchanged until it is acknowledged or errored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| video_en | input | 1 | Enables fetching; low resets the frame |
| depth_sel | input | 2 | Stored pixel format |
| pseudo_en | input | 1 | 8-bit pixels index the colour table |
| burst_sel | input | 2 | Words per burst selector |
| page_swap_en | input | 1 | Flip page at frame end |
| clut_swap_en | input | 1 | Flip colour table bank at frame end |
| base_a | input | 30 | Page A word base address |
| base_b | input | 30 | Page B word base address |
| clut_base | input | 21 | Colour table base, byte-address bits 31:11 |
| width_px | input | 16 | Visible pixels per line |
| height_ln | input | 16 | Visible lines per frame |
| m_cyc | output | 1 | Bus cycle active |
| m_stb | output | 1 | Bus strobe |
| m_cab | output | 1 | Consecutive-address burst |
| m_we | output | 1 | Write enable, always 0 |
| m_adr | output | 30 | Word address (byte bits 31:2) |
| m_sel | output | 4 | Byte selects |
| m_ack | input | 1 | Bus acknowledge |
| m_err | input | 1 | Bus error response |
| m_dat | input | 32 | Read data |
| fifo_full | input | 1 | Line FIFO full |
| fifo_free | input | 9 | Free FIFO entries |
| pix_wr | output | 1 | Pixel write strobe |
| pix_data | output | 24 | RGB pixel |
| page_sel | output | 1 | Active video page |
| clut_sel | output | 1 | Active colour table bank |
| swap_pulse | output | 1 | Page has just flipped |
| fatal_irq | output | 1 | Sticky bus error interrupt |

## Verification
The hardest state to reach is the end of a frame whose pixel count is not a multiple of the burst size. There the final burst must be cut short, and the page and table bank must flip while colour table reads for the same frame are still being made. The bench picks small random frame sizes, often odd, with all burst lengths and formats. It runs several frames per setting, with a slow random FIFO drain, so that room waits, short bursts and bank flips coincide. Directed runs add a one-pixel frame, a disable in mid-frame and an injected bus error during a burst.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_BURST, ST_DRAIN, ST_LUT, ST_HALT
  } fbf_state_e;

  // log2 of stored pixels per 32-bit word
  function automatic logic [1:0] lane_shift(input logic [1:0] depth);
    case (depth)
      2'd0:    return 2'd2;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // highest lane index within a word
  function automatic logic [1:0] lane_mask(input logic [1:0] depth);
    case (depth)
      2'd0:    return 2'd3;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] burst_words(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    return 8'(w >> {lane, 3'b000});
  endfunction

  function automatic logic [23:0] unpack_pixel(input logic [31:0] w,
                                               input logic [1:0] depth,
                                               input logic [1:0] lane);
    logic [15:0] h;
    logic [7:0]  b;
    b = lane_byte(w, lane);
    h = lane[0] ? w[31:16] : w[15:0];
    case (depth)
      2'd0:    return {b, b, b};
      2'd1:    return {h[15:11], h[15:13], h[10:5], h[10:9], h[4:0], h[4:2]};
      2'd2:    return w[23:0];
      default: return w[31:8];
    endcase
  endfunction

  function automatic logic [29:0] clut_word_addr(input logic [20:0] base,
                                                 input logic bank,
                                                 input logic [7:0] idx);
    return {base, bank, idx};
  endfunction

endpackage

// File: rtl/fbf_word_buf.sv
module fbf_word_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(i)) slot_q <= wr_data;
    end
    assign slots[i] = slot_q;
  end

  assign rd_data = slots[rd_idx];
endmodule

// File: rtl/fbf_page_ctrl.sv
module fbf_page_ctrl #(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end,
  input  logic          page_swap_en,
  input  logic          clut_swap_en,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  output logic          page_sel,
  output logic          clut_sel,
  output logic          swap_pulse,
  output logic [AW-1:0] active_base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_sel   <= 1'b0;
      clut_sel   <= 1'b0;
      swap_pulse <= 1'b0;
    end else begin
      swap_pulse <= frame_end && page_swap_en;
      if (frame_end && page_swap_en) page_sel <= ~page_sel;
      if (frame_end && clut_swap_en) clut_sel <= ~clut_sel;
    end
  end

  assign active_base = page_sel ? base_b : base_a;

  assert_swap_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |-> (page_sel != $past(page_sel)));
endmodule

// File: rtl/fbf_fetch_master.sv
module fbf_fetch_master
  import fbf_pkg::*;
#(
  parameter int DIM_W  = 16,
  parameter int FREE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              video_en,
  input  logic [1:0]        depth_sel,
  input  logic              pseudo_en,
  input  logic [1:0]        burst_sel,
  input  logic              page_swap_en,
  input  logic              clut_swap_en,
  input  logic [29:0]       base_a,
  input  logic [29:0]       base_b,
  input  logic [20:0]       clut_base,
  input  logic [DIM_W-1:0]  width_px,
  input  logic [DIM_W-1:0]  height_ln,
  output logic              m_cyc,
  output logic              m_stb,
  output logic              m_cab,
  output logic              m_we,
  output logic [29:0]       m_adr,
  output logic [3:0]        m_sel,
  input  logic              m_ack,
  input  logic              m_err,
  input  logic [31:0]       m_dat,
  input  logic              fifo_full,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              pix_wr,
  output logic [23:0]       pix_data,
  output logic              page_sel,
  output logic              clut_sel,
  output logic              swap_pulse,
  output logic              fatal_irq
);
  localparam int BSEL_W    = 2;
  localparam int BURST_MAX = 1 << ((1 << BSEL_W) - 1);
  localparam int IDX_W     = $clog2(BURST_MAX);
  localparam int CNT_W     = IDX_W + 1;
  localparam int PIX_W     = 2 * DIM_W;

  fbf_state_e        state;
  logic [1:0]        cfg_depth;
  logic              cfg_pseudo;
  logic [BSEL_W-1:0] cfg_bsel;
  logic [29:0]       vid_adr;
  logic [PIX_W-1:0]  pix_left, words_left;
  logic [CNT_W-1:0]  blen, wcnt;
  logic [IDX_W-1:0]  rd_word;
  logic [1:0]        lane;
  logic              frame_start;

  // named internal events
  logic              frame_end, advance, lut_mode, room_ok, last_in_burst, buf_wr;
  logic [PIX_W-1:0]  total, words_total, need;
  logic [CNT_W-1:0]  blen_next;
  logic [31:0]       cur_word;
  logic [29:0]       active_base;

  assign total       = PIX_W'(width_px) * PIX_W'(height_ln);
  assign words_total = (total + PIX_W'(lane_mask(depth_sel))) >> lane_shift(depth_sel);
  assign blen_next   = (words_left < PIX_W'(burst_words(cfg_bsel))) ?
                       CNT_W'(words_left) : CNT_W'(burst_words(cfg_bsel));
  assign need        = PIX_W'(blen_next) << lane_shift(cfg_depth);
  assign room_ok     = PIX_W'(fifo_free) >= need;
  assign lut_mode    = cfg_pseudo && (cfg_depth == 2'd0);
  assign last_in_burst = (lane == lane_mask(cfg_depth)) &&
                         ({1'b0, rd_word} == blen - CNT_W'(1));
  assign buf_wr      = video_en && (state == ST_BURST) && m_ack && !m_err;

  fbf_word_buf #(.DEPTH(BURST_MAX), .W(32)) u_buf (
    .clk     (clk),
    .wr_en   (buf_wr),
    .wr_idx  (wcnt[IDX_W-1:0]),
    .wr_data (m_dat),
    .rd_idx  (rd_word),
    .rd_data (cur_word)
  );

  fbf_page_ctrl #(.AW(30)) u_page (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end    (frame_end),
    .page_swap_en (page_swap_en),
    .clut_swap_en (clut_swap_en),
    .base_a       (base_a),
    .base_b       (base_b),
    .page_sel     (page_sel),
    .clut_sel     (clut_sel),
    .swap_pulse   (swap_pulse),
    .active_base  (active_base)
  );

  // bus and pixel outputs
  always_comb begin
    m_cyc    = video_en && (state == ST_BURST || state == ST_LUT);
    m_stb    = m_cyc;
    m_cab    = video_en && (state == ST_BURST) && (blen > CNT_W'(1));
    m_we     = 1'b0;
    m_sel    = 4'hF;
    m_adr    = (state == ST_LUT) ?
               clut_word_addr(clut_base, clut_sel, lane_byte(cur_word, lane)) : vid_adr;
    pix_wr   = 1'b0;
    advance  = 1'b0;
    pix_data = unpack_pixel(cur_word, cfg_depth, lane);
    if (video_en) begin
      if (state == ST_DRAIN && !lut_mode && !fifo_full) begin
        pix_wr  = 1'b1;
        advance = 1'b1;
      end else if (state == ST_LUT && m_ack && !m_err) begin
        pix_wr   = 1'b1;
        advance  = 1'b1;
        pix_data = m_dat[23:0];
      end
    end
    frame_end = advance && (pix_left == PIX_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      frame_start <= 1'b1;
      fatal_irq   <= 1'b0;
      cfg_depth   <= '0;
      cfg_pseudo  <= 1'b0;
      cfg_bsel    <= '0;
      vid_adr     <= '0;
      pix_left    <= '0;
      words_left  <= '0;
      blen        <= '0;
      wcnt        <= '0;
      rd_word     <= '0;
      lane        <= '0;
    end else if (!video_en) begin
      state       <= ST_IDLE;
      frame_start <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          state       <= ST_REQ;
          frame_start <= 1'b1;
        end
        ST_REQ: begin
          if (frame_start) begin
            cfg_depth   <= depth_sel;
            cfg_pseudo  <= pseudo_en;
            cfg_bsel    <= burst_sel;
            vid_adr     <= active_base;
            pix_left    <= total;
            words_left  <= words_total;
            frame_start <= (total == '0);
          end else if (room_ok) begin
            blen  <= blen_next;
            wcnt  <= '0;
            state <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (m_err) begin
            state     <= ST_HALT;
            fatal_irq <= 1'b1;
          end else if (m_ack) begin
            vid_adr    <= vid_adr + 30'd1;
            words_left <= words_left - PIX_W'(1);
            wcnt       <= wcnt + CNT_W'(1);
            if (wcnt == blen - CNT_W'(1)) begin
              state   <= ST_DRAIN;
              rd_word <= '0;
              lane    <= '0;
            end
          end
        end
        ST_DRAIN: if (lut_mode && !fifo_full) state <= ST_LUT;
        ST_LUT: begin
          if (m_err) begin
            state     <= ST_HALT;
            fatal_irq <= 1'b1;
          end else if (m_ack) begin
            state <= ST_DRAIN;
          end
        end
        default: state <= ST_HALT;
      endcase

      if (advance) begin
        pix_left <= pix_left - PIX_W'(1);
        if (frame_end) begin
          state       <= ST_REQ;
          frame_start <= 1'b1;
        end else if (last_in_burst) begin
          state <= ST_REQ;
        end else if (lane == lane_mask(cfg_depth)) begin
          lane    <= '0;
          rd_word <= rd_word + IDX_W'(1);
        end else begin
          lane <= lane + 2'd1;
        end
      end
    end
  end

  assert_cab_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_cab |-> m_cyc);
  assert_no_write_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !pix_wr);
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_irq |=> fatal_irq);
  assert_err_stops_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal_irq) |-> !m_cyc);
  assert_err_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cyc && m_err) |=> fatal_irq);
  assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !video_en |-> (!m_cyc && !pix_wr));
  assert_hold_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_stb && !m_ack && !m_err) |=> (!video_en || (m_stb && $stable(m_adr))));
endmodule

// File: tb/fbf_fetch_master_tb.sv
module fbf_fetch_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FIFO_DEPTH = 64;
  localparam int WD_LIMIT   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        video_en = 0, pseudo_en = 0, page_swap_en = 0, clut_swap_en = 0;
  logic [1:0]  depth_sel = 0, burst_sel = 0;
  logic [29:0] base_a = 30'h1000, base_b = 30'h20000;
  logic [20:0] clut_base = 21'h100000;
  logic [15:0] width_px = 4, height_ln = 2;
  logic        m_cyc, m_stb, m_cab, m_we, m_ack, m_err;
  logic [29:0] m_adr;
  logic [3:0]  m_sel;
  logic [31:0] m_dat;
  logic        fifo_full, pix_wr, page_sel, clut_sel, swap_pulse, fatal_irq;
  logic [8:0]  fifo_free;
  logic [23:0] pix_data;

  fbf_fetch_master dut_i (
    .clk(clk), .rst_n(rst_n), .video_en(video_en), .depth_sel(depth_sel),
    .pseudo_en(pseudo_en), .burst_sel(burst_sel), .page_swap_en(page_swap_en),
    .clut_swap_en(clut_swap_en), .base_a(base_a), .base_b(base_b),
    .clut_base(clut_base), .width_px(width_px), .height_ln(height_ln),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_cab(m_cab), .m_we(m_we), .m_adr(m_adr),
    .m_sel(m_sel), .m_ack(m_ack), .m_err(m_err), .m_dat(m_dat),
    .fifo_full(fifo_full), .fifo_free(fifo_free), .pix_wr(pix_wr),
    .pix_data(pix_data), .page_sel(page_sel), .clut_sel(clut_sel),
    .swap_pulse(swap_pulse), .fatal_irq(fatal_irq)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: contents are a hash of the word address
  function automatic logic [31:0] mem_word(input logic [29:0] a);
    logic [31:0] x;
    x = {2'b00, a};
    return (x * 32'h9E3779B1) ^ (x >> 5) ^ 32'h5A5A0000;
  endfunction
  assign m_dat = mem_word(m_adr);

  // bus slave with random wait states and one-shot error injection
  logic err_req = 0, err_done = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack <= 0; m_err <= 0; err_done <= 0;
    end else begin
      if (!err_req) err_done <= 0;
      if (m_stb && !m_ack && !m_err && err_req && !err_done) begin
        m_err <= 1; m_ack <= 0; err_done <= 1;
      end else begin
        m_err <= 0;
        m_ack <= m_stb && !m_ack && !m_err && ($urandom % 4 != 0);
      end
    end
  end

  // line FIFO occupancy model
  int fcount = 0;
  int pop_pct = 50;
  logic pop = 0;
  assign fifo_full = (fcount >= FIFO_DEPTH);
  assign fifo_free = 9'(FIFO_DEPTH - fcount);
  always @(posedge clk) begin
    if (!rst_n) fcount <= 0;
    else fcount <= fcount + (pix_wr ? 1 : 0) - (pop ? 1 : 0);
  end
  always @(negedge clk) pop <= (fcount > 0) && (($urandom % 100) < pop_pct);

  // scoreboard state
  int k = 0, frames_done = 0;
  logic exp_page = 0, exp_bank = 0;
  logic [29:0] vid_next;
  int acks = 0, burst_n = 0;
  bit cab_seen = 0, aborted = 0, in_vid = 0;
  logic prev_cyc = 0, prev_stb = 0, prev_ack = 0, prev_err = 0;
  logic [29:0] prev_adr = 0;

  function automatic int ppw_of(input logic [1:0] d);
    return (d == 0) ? 4 : (d == 1) ? 2 : 1;
  endfunction
  function automatic logic [29:0] cur_base();
    return exp_page ? base_b : base_a;
  endfunction

  function automatic logic [23:0] exp_pix(input int idx);
    int ppw, ln;
    logic [31:0] w;
    logic [7:0] by;
    logic [15:0] h;
    logic [7:0] r, g, b;
    ppw = ppw_of(depth_sel);
    ln  = idx % ppw;
    w   = mem_word(cur_base() + 30'(idx / ppw));
    case (depth_sel)
      2'd0: begin
        by = 8'((w >> (8 * ln)) & 32'hFF);
        if (pseudo_en) return 24'(mem_word({clut_base, exp_bank, by}));
        return {by, by, by};
      end
      2'd1: begin
        h = 16'((w >> (16 * ln)) & 32'hFFFF);
        r = 8'(((h >> 11) << 3) | (h >> 13));
        g = 8'((((h >> 5) & 16'h3F) << 2) | ((h >> 9) & 16'h3));
        b = 8'(((h & 16'h1F) << 3) | ((h >> 2) & 16'h7));
        return {r, g, b};
      end
      2'd2: return 24'(w);
      default: return 24'(w >> 8);
    endcase
  endfunction

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    int total, ppw, wt, fetched, rem;
    if (rst_n) begin
      total = int'(width_px) * int'(height_ln);
      ppw   = ppw_of(depth_sel);
      wt    = (total + ppw - 1) / ppw;
      if (!video_en) begin
        aborted = 1;
        chk(!m_cyc && !pix_wr, "R10 quiet while disabled", {30'b0, m_cyc, pix_wr}, 0);
      end
      if (m_stb) chk(m_sel == 4'hF && !m_we, "R1 full-word read", {27'b0, m_we, m_sel}, 32'hF);
      if (prev_stb && !prev_ack && !prev_err && m_stb && video_en)
        chk(m_adr == prev_adr, "R12 request held", {2'b0, m_adr}, {2'b0, prev_adr});
      if (pix_wr) begin
        chk(!fifo_full, "R3 write while full", 1, 0);
        chk(pix_data == exp_pix(k), (depth_sel == 0) ? "R6 8-bit pixel" : "R5 pixel format",
            {8'b0, pix_data}, {8'b0, exp_pix(k)});
        k++;
        if (k == total) begin
          k = 0;
          frames_done++;
          if (page_swap_en) exp_page = ~exp_page;
          if (clut_swap_en) exp_bank = ~exp_bank;
          vid_next = cur_base();
        end
      end
      if (swap_pulse) begin
        chk(page_sel == exp_page, "R7 page after swap pulse", {31'b0, page_sel}, {31'b0, exp_page});
        chk(clut_sel == exp_bank, "R8 bank at frame end", {31'b0, clut_sel}, {31'b0, exp_bank});
      end
      if (m_cyc && !prev_cyc && !m_adr[29]) begin
        in_vid  = 1; aborted = !video_en; acks = 0; cab_seen = 0;
        fetched = int'(m_adr - cur_base());
        rem     = wt - fetched;
        burst_n = (rem < (1 << burst_sel)) ? rem : (1 << burst_sel);
        chk(int'(fifo_free) >= burst_n * ppw, "R3 room before burst", 32'(fifo_free), 32'(burst_n * ppw));
      end
      if (m_err && prev_stb) aborted = 1;
      if (in_vid && m_cab) cab_seen = 1;
      if (m_stb && m_ack && !m_adr[29]) begin
        chk(m_adr == vid_next, "R4 video address", {2'b0, m_adr}, {2'b0, vid_next});
        vid_next = vid_next + 30'd1;
        acks++;
      end
      if (prev_cyc && !m_cyc && in_vid) begin
        in_vid = 0;
        if (!aborted) begin
          chk(acks == burst_n, "R2 burst length", 32'(acks), 32'(burst_n));
          chk(cab_seen == (burst_n > 1), "R2 burst flag", {31'b0, cab_seen}, 32'(burst_n > 1));
        end
      end
      prev_cyc = m_cyc; prev_stb = m_stb; prev_ack = m_ack; prev_err = m_err; prev_adr = m_adr;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      summary();
      $finish;
    end
  end

  task automatic stop_video();
    @(posedge clk); #1 video_en = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic start_video();
    #1;
    k = 0;
    frames_done = 0;
    vid_next = cur_base();
    video_en = 1;
  endtask

  task automatic wait_frames(input int n, input string req);
    int guard = 0;
    while (frames_done < n && guard < 30000) begin @(posedge clk); guard++; end
    chk(frames_done >= n, req, 32'(frames_done), 32'(n));
  endtask

  task automatic run_cfg(input logic [1:0] d, input logic ps, input logic [1:0] bs,
                         input logic psw, input logic csw, input int w, input int h,
                         input int nf, input string req);
    logic p0, b0;
    stop_video();
    depth_sel = d; pseudo_en = ps; burst_sel = bs; page_swap_en = psw; clut_swap_en = csw;
    width_px = 16'(w); height_ln = 16'(h);
    base_a = 30'($urandom) & 30'h0FFF_FFF0;
    base_b = 30'($urandom) & 30'h0FFF_FFF0;
    clut_base = 21'h100000 | 21'($urandom & 32'hFFFFF);
    p0 = exp_page; b0 = exp_bank;
    start_video();
    wait_frames(nf, req);
    #2;
    chk(page_sel == (psw ? p0 ^ 1'(nf) : p0), "R7 page after frames", {31'b0, page_sel}, {31'b0, exp_page});
    chk(clut_sel == (csw ? b0 ^ 1'(nf) : b0), "R8 bank after frames", {31'b0, clut_sel}, {31'b0, exp_bank});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    #1;
    chk(!page_sel && !clut_sel && !swap_pulse && !fatal_irq && !m_cyc && !pix_wr, "R11 reset state",
        {26'b0, page_sel, clut_sel, swap_pulse, fatal_irq, m_cyc, pix_wr}, 0);
    rst_n = 1;

    // directed corners
    pop_pct = 80;
    run_cfg(2'd0, 1, 2'd3, 1, 1, 1, 1, 3, "R6 one-pixel pseudo frame");
    run_cfg(2'd1, 0, 2'd2, 1, 0, 7, 3, 2, "R5 565 odd frame");
    run_cfg(2'd3, 0, 2'd0, 0, 0, 5, 2, 2, "R5 32-bit single bursts");
    run_cfg(2'd0, 0, 2'd3, 0, 1, 9, 4, 2, "R6 greyscale bursts");
    pop_pct = 10;
    run_cfg(2'd2, 0, 2'd3, 1, 0, 12, 5, 2, "R3 slow drain");

    // constrained random settings
    for (int i = 0; i < 12; i++) begin
      pop_pct = 10 + ($urandom % 80);
      run_cfg(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
              1 + ($urandom % 12), 1 + ($urandom % 6), 2, "R4 random frame");
    end

    // disable in mid-frame, then restart from the active base
    pop_pct = 60;
    run_cfg(2'd0, 0, 2'd2, 1, 0, 10, 4, 1, "R10 before disable");
    begin
      int guard = 0;
      while (k < 5 && guard < 5000) begin @(posedge clk); guard++; end
    end
    stop_video();
    chk(!m_cyc, "R10 idle after disable", {31'b0, m_cyc}, 0);
    start_video();
    wait_frames(2, "R10 restart from base");

    // bus error during a burst
    stop_video();
    depth_sel = 2'd2; burst_sel = 2'd3; pseudo_en = 0;
    #1 err_req = 1;
    start_video();
    begin
      int guard = 0;
      while (!fatal_irq && guard < 5000) begin @(posedge clk); guard++; end
    end
    err_req = 0;
    repeat (20) begin
      @(negedge clk);
      chk(fatal_irq && !m_cyc, "R9 halted after error", {30'b0, fatal_irq, m_cyc}, 32'h2);
    end
    stop_video();
    chk(fatal_irq, "R9 irq sticky", {31'b0, fatal_irq}, 1);
    start_video();
    wait_frames(1, "R9 resumes after disable");
    chk(fatal_irq, "R9 irq still set", {31'b0, fatal_irq}, 1);

    // reset clears the interrupt and page state
    stop_video();
    rst_n = 0;
    @(negedge clk);
    chk(!page_sel && !clut_sel && !swap_pulse && !fatal_irq && !m_cyc && !pix_wr, "R11 reset clears",
        {26'b0, page_sel, clut_sel, swap_pulse, fatal_irq, m_cyc, pix_wr}, 0);
    summary();
    $finish;
  end
endmodule